// File: doc/BRIEF.md
# Limit-Match Interval Timer

This block is a memory-mapped 32-bit interval timer. A prescaler outside the block supplies a one-cycle tick every 500 ns. On each tick the counter moves up by one unit, and one unit is worth 0x200 in the register view. Software programs a limit. When the count arrives at that limit, the count goes back to zero, a sticky reached flag is set and a level interrupt is raised.

A limit of zero makes the counter free-running across its whole range, with no flag and no interrupt. Reading the limit is how software acknowledges the event. A second write address changes the limit without disturbing the running count.

The access port takes one word access per cycle. Read data is combinational from the held state. Side effects of an access take place at the clock edge that ends the access.

Top module: `lim_timer`

## Requirements
- R1: After reset the limit, the count and the reached flag are zero, `irq` is low, and the counter runs free on ticks without any setup.
- R2: Each cycle with `tick` high adds one unit to the count. Reading byte offset 0x4 returns the count in bits CNT_LSB+COUNT_W-1:CNT_LSB (30:9 by default), with bits 8:0 reading zero. Without a tick the count holds.
- R3: A write to offset 0x0 takes the limit from data bits CNT_LSB+COUNT_W-1:CNT_LSB and drops every other bit. It restarts the count at zero and lowers `irq`, but leaves the reached flag as it is. A tick in the same cycle is discarded.
- R4: With a nonzero limit L, the tick that would bring the count to L instead sets the count to zero, sets the reached flag and raises `irq`. This happens L ticks after a restart. `irq` is never high while the reached flag is clear.
- R5: With a limit of zero the count wraps from its all-ones value to zero. The reached flag is never set and `irq` stays low.
- R6: A write to offset 0x8 replaces the limit and leaves the count untouched. A tick in the same cycle is matched against the limit held before the write.
- R7: A read of offset 0x0 returns the limit in its field, with bit 31 zero. The read clears the reached flag and lowers `irq`. If a match happens in the same cycle, the match wins and both stay set.
- R8: A read of offset 0x4 places the reached flag in bit 31 and clears nothing.
- R9: A write to offset 0x4 has no effect.
- R10: Reads of offsets 0x8, 0xC, 0x10 and any other undefined word return zero. Writes to undefined words change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase pulse, one per counting step |
| acc_en | input | 1 | Access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address in the register window |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, zero when no read is selected |
| irq | output | 1 | Level interrupt |

## Verification
The bench uses a 4-bit count field so that every limit from 1 to 15 can be swept. For each limit it checks the count one tick before the match and at the match itself, which separates an off-by-one period from a correct one. A free-run stretch of more than sixteen ticks exposes wrap errors and any spurious flag when the limit is zero.

Single-cycle collisions are driven on purpose: a tick with a limit write, and a tick with a limit read. Together with the no-reset limit write, these separate the priority rules from each other. Writes to the counter word and to unused words are followed by readback of both registers, to show that nothing moved.

// File: rtl/lim_timer_pkg.sv
package lim_timer_pkg;
  localparam int DATA_W = 32;
  localparam int FLAG_BIT = 31;

  // word index = byte address >> 2
  localparam logic [2:0] WORD_LIMIT      = 3'd0;
  localparam logic [2:0] WORD_COUNT      = 3'd1;
  localparam logic [2:0] WORD_LIMIT_KEEP = 3'd2;

  typedef struct packed {
    logic lim_wr;   // limit write with count restart
    logic keep_wr;  // limit write, count kept
    logic lim_rd;   // limit read (acknowledge)
    logic cnt_rd;   // counter read
  } acc_dec_t;
endpackage

// File: rtl/lim_timer_dec.sv
module lim_timer_dec
  import lim_timer_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  output acc_dec_t          dec
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;

  always_comb begin
    word = acc_addr[ADDR_W-1:2];
    dec.lim_wr  = acc_en &&  acc_wr && (word == WORD_W'(WORD_LIMIT));
    dec.keep_wr = acc_en &&  acc_wr && (word == WORD_W'(WORD_LIMIT_KEEP));
    dec.lim_rd  = acc_en && !acc_wr && (word == WORD_W'(WORD_LIMIT));
    dec.cnt_rd  = acc_en && !acc_wr && (word == WORD_W'(WORD_COUNT));
  end
endmodule

// File: rtl/lim_timer_cnt.sv
module lim_timer_cnt #(
  parameter int COUNT_W = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               restart,
  input  logic [COUNT_W-1:0] limit,
  output logic [COUNT_W-1:0] count_q,
  output logic               hit
);
  logic [COUNT_W-1:0] count_d;
  logic [COUNT_W-1:0] count_inc;
  logic               count_en;

  always_comb begin
    count_inc = count_q + COUNT_W'(1);
    hit       = tick && !restart && (limit != '0) && (count_inc == limit);
    count_en  = tick || restart;
    if (restart || hit) count_d = '0;
    else                count_d = count_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end
endmodule

// File: rtl/lim_timer_flag.sv
module lim_timer_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic lim_wr,
  input  logic lim_rd,
  output logic reached_q,
  output logic irq_q
);
  logic reached_d;
  logic irq_d;

  always_comb begin
    if (hit)         reached_d = 1'b1;
    else if (lim_rd) reached_d = 1'b0;
    else             reached_d = reached_q;

    if (lim_wr)      irq_d = 1'b0;
    else if (hit)    irq_d = 1'b1;
    else if (lim_rd) irq_d = 1'b0;
    else             irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reached_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      reached_q <= reached_d;
      irq_q     <= irq_d;
    end
  end
endmodule

// File: rtl/lim_timer.sv
module lim_timer
  import lim_timer_pkg::*;
#(
  parameter int COUNT_W = 22,
  parameter int CNT_LSB = 9,
  parameter int ADDR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  output logic              irq
);
  localparam int FIELD_HI = CNT_LSB + COUNT_W - 1;

  acc_dec_t           dec;
  logic [COUNT_W-1:0] limit_q;
  logic [COUNT_W-1:0] limit_d;
  logic               limit_en;
  logic [COUNT_W-1:0] count_q;
  logic               cnt_hit;
  logic               reached_q;
  logic               irq_q;

  lim_timer_dec #(.ADDR_W(ADDR_W)) u_dec (
    .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr), .dec(dec)
  );

  always_comb begin
    limit_en = dec.lim_wr || dec.keep_wr;
    limit_d  = acc_wdata[FIELD_HI:CNT_LSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        limit_q <= '0;
    else if (limit_en) limit_q <= limit_d;
  end

  lim_timer_cnt #(.COUNT_W(COUNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(dec.lim_wr),
    .limit(limit_q), .count_q(count_q), .hit(cnt_hit)
  );

  lim_timer_flag u_flag (
    .clk(clk), .rst_n(rst_n), .hit(cnt_hit), .lim_wr(dec.lim_wr),
    .lim_rd(dec.lim_rd), .reached_q(reached_q), .irq_q(irq_q)
  );

  always_comb begin
    acc_rdata = '0;
    if (dec.lim_rd) begin
      acc_rdata[FIELD_HI:CNT_LSB] = limit_q;
    end else if (dec.cnt_rd) begin
      acc_rdata[FIELD_HI:CNT_LSB] = count_q;
      acc_rdata[FLAG_BIT]         = reached_q;
    end
    irq = irq_q;
  end
endmodule

// File: rtl/lim_timer_chk.sv
module lim_timer_chk #(
  parameter int COUNT_W = 22,
  parameter int ADDR_W  = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic               acc_en,
  input logic               acc_wr,
  input logic [ADDR_W-1:0]  acc_addr,
  input logic               irq,
  input logic [COUNT_W-1:0] limit_q,
  input logic [COUNT_W-1:0] count_q,
  input logic               reached_q,
  input logic               cnt_hit
);
  logic [ADDR_W-3:0] word;
  logic wr_lim, wr_cnt, rd_lim;

  always_comb begin
    word   = acc_addr[ADDR_W-1:2];
    wr_lim = acc_en &&  acc_wr && (word == '0);
    wr_cnt = acc_en &&  acc_wr && (word == (ADDR_W-2)'(1));
    rd_lim = acc_en && !acc_wr && (word == '0);
  end

  assert_irq_needs_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> reached_q);
  assert_hit_sets_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_hit |=> (reached_q && irq && count_q == '0));
  assert_freerun_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_q == '0 && !reached_q) |=> !reached_q);
  assert_limit_wr_drops_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lim |=> (!irq && count_q == '0));
  assert_count_wr_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && !tick) |=> $stable(count_q));
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_lim) |=> $stable(count_q));
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lim && !cnt_hit) |=> (!reached_q && !irq));
endmodule

bind lim_timer lim_timer_chk #(.COUNT_W(COUNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .acc_en(acc_en), .acc_wr(acc_wr),
  .acc_addr(acc_addr), .irq(irq), .limit_q(limit_q), .count_q(count_q),
  .reached_q(reached_q), .cnt_hit(cnt_hit)
);

// File: tb/lim_timer_bench.sv
module lim_timer_bench;
  localparam int CW = 4;
  localparam logic [31:0] FLAG = 32'h8000_0000;

  logic clk = 1'b0;
  logic rst_n, tick, acc_en, acc_wr, irq;
  logic [4:0]  acc_addr;
  logic [31:0] acc_wdata, acc_rdata, rd;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lim_timer #(.COUNT_W(CW)) u_lim_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .irq(irq)
  );

  function automatic logic [31:0] cv(int k);
    return 32'((k % 16) << 9);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [4:0] a, input logic [31:0] wd,
                     input logic tk, output logic [31:0] r);
    acc_en = 1'b1; acc_wr = wr; acc_addr = a; acc_wdata = wd; tick = tk;
    #1 r = acc_rdata;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic rdchk(string req, logic [4:0] a, logic [31:0] exp);
    logic [31:0] r;
    bus(1'b0, a, 32'h0, 1'b0, r);
    chk(req, r, exp);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    logic [31:0] r;
    bus(1'b1, a, d, 1'b0, r);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; acc_en = 1'b0; acc_wr = 1'b0;
    acc_addr = '0; acc_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and running counter
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rdchk("R1 count", 5'h04, 32'h0);
    ticks(3);
    rdchk("R1 runs", 5'h04, cv(3));
    rdchk("R1 limit", 5'h00, 32'h0);

    // R2 R3 R4 R7 R8: sweep every limit
    for (int L = 1; L < 16; L++) begin
      wr(5'h00, 32'hF000_01FF | 32'(L << 9));
      rdchk("R3 mask", 5'h00, cv(L));
      ticks(L - 1);
      rdchk("R2 before match", 5'h04, cv(L - 1));
      chk("R4 no irq early", {31'b0, irq}, 32'h0);
      ticks(1);
      chk("R4 irq", {31'b0, irq}, 32'h1);
      rdchk("R4 wrap+flag", 5'h04, FLAG);
      rdchk("R8 no clear", 5'h04, FLAG);
      rdchk("R7 limit read", 5'h00, cv(L));
      chk("R7 irq low", {31'b0, irq}, 32'h0);
      rdchk("R7 flag clear", 5'h04, 32'h0);
    end

    // R5 free run
    wr(5'h00, 32'h0);
    for (int k = 1; k <= 20; k++) begin
      ticks(1);
      rdchk("R5 free count", 5'h04, cv(k));
      chk("R5 no irq", {31'b0, irq}, 32'h0);
    end

    // R6 limit change without restart
    wr(5'h00, cv(10));
    ticks(3);
    wr(5'h08, cv(5));
    rdchk("R6 count kept", 5'h04, cv(3));
    rdchk("R6 new limit", 5'h00, cv(5));
    ticks(1);
    rdchk("R6 step", 5'h04, cv(4));
    ticks(1);
    rdchk("R6 match", 5'h04, FLAG);
    chk("R6 irq", {31'b0, irq}, 32'h1);

    // R3 limit write lowers irq, keeps flag
    wr(5'h00, cv(7));
    chk("R3 irq low", {31'b0, irq}, 32'h0);
    rdchk("R3 flag kept", 5'h04, FLAG);
    ticks(2);
    rdchk("R3 restart", 5'h04, FLAG | cv(2));

    // R7 read colliding with match: match wins
    ticks(4);
    bus(1'b0, 5'h00, 32'h0, 1'b1, rd);
    chk("R7 read data", rd, cv(7));
    rdchk("R7 match wins", 5'h04, FLAG);
    chk("R7 irq stays", {31'b0, irq}, 32'h1);
    rdchk("R7 ack", 5'h00, cv(7));

    // R9 counter write ignored
    ticks(2);
    wr(5'h04, 32'h0000_1A00);
    rdchk("R9 count", 5'h04, cv(2));

    // R10 undefined offsets
    wr(5'h0C, 32'hFFFF_FFFF);
    wr(5'h10, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    rdchk("R10 rd 0x8", 5'h08, 32'h0);
    rdchk("R10 rd 0xC", 5'h0C, 32'h0);
    rdchk("R10 rd 0x10", 5'h10, 32'h0);
    rdchk("R10 rd 0x1C", 5'h1C, 32'h0);
    rdchk("R10 limit kept", 5'h00, cv(7));
    rdchk("R10 count kept", 5'h04, cv(2));

    // R3 tick colliding with limit write is discarded
    bus(1'b1, 5'h00, cv(3), 1'b1, rd);
    rdchk("R3 tick discarded", 5'h04, 32'h0);

    finish_run();
  end
endmodule